// File: doc/BRIEF.md
# Table Access Mailbox Responder

This block answers table-read requests that come in through a data-object exchange mailbox. A request gives its object length in dwords and the handle of the table entry it wants. If the request is long enough and the handle names an existing entry, the block reads that entry's descriptor from a small on-chip table store. The descriptor holds a byte length and a base word address. The block then streams a three-dword response header and the entry's payload dwords into the read mailbox, one dword per clock, under a valid/ready handshake.

The header reports a total length in dwords. It also reports the handle software should ask for next, so a driver can walk the whole table by feeding each returned handle back in until it receives the all-ones terminator. When the last dword has been taken, the block raises a response-ready flag and adds the response length to its mailbox length count. It then refuses new requests until the mailbox is cleared.

The table contents are computed from parameters. Entry `h` holds `B0 + STEP*h` bytes, 6 + 5h by default. Entries are packed back to back in whole dwords. Each stored word carries a fixed tag in its upper half and its own store address in its lower half.

Top module: `tam_responder`

## Requirements
- R1: A request whose length is below 3 dwords is discarded. No word is produced, `req_ready` stays 1 and `mbox_len_dw` does not change.
- R2: A request whose handle is not below the entry count (4 by default) is discarded in the same way as R1. No word is produced and `req_ready` stays 1.
- R3: The first response dword holds the vendor ID 16'h1E98 in bits [15:0], the object type 8'h02 in bits [23:16] and zero in bits [31:24].
- R4: The second response dword holds, in bits [17:0], the total length in dwords, and zero above. The total length is 3 plus the entry's byte count divided by 4, rounded up.
- R5: The third response dword holds the response code 8'h00 in bits [7:0] and the table type 8'h00 in bits [15:8]. Bits [31:16] hold the next handle: the requested handle plus one, or 16'hFFFF when the requested entry is the last one.
- R6: The payload follows from the fourth dword on, with ceil(bytes/4) dwords. Payload word k of entry h is {16'hDA7A, 16'(base(h)+k)}, where base(h) is the sum of the dword counts of entries 0 to h-1.
- R7: The first dword is presented one cycle after the request is accepted. With `rd_ready` held high, one dword moves per clock. While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold.
- R8: `rsp_ready` rises in the cycle after the last dword is taken, and `mbox_len_dw` grows by the total length at that point. `req_ready` is 0 from acceptance until a clear.
- R9: A `mbox_clear` pulse while the response is waiting drops `rsp_ready` and `mbox_len_dw` to 0 and returns `req_ready` to 1 on the next cycle.
- R10: After reset, `rd_valid` and `rsp_ready` are 0, `mbox_len_dw` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_len_dw | input | 18 | Request object length in dwords |
| req_handle | input | 16 | Requested entry handle |
| req_ready | output | 1 | Block idle and able to take a request |
| rd_valid | output | 1 | Read-mailbox dword valid |
| rd_data | output | 32 | Read-mailbox dword |
| rd_ready | input | 1 | Read mailbox accepts the dword |
| rsp_ready | output | 1 | Complete response waiting in the mailbox |
| mbox_len_dw | output | 18 | Dwords written to the read mailbox since the last clear |
| mbox_clear | input | 1 | Mailbox drained; reopen for requests |

## Verification
Some properties are checked by the assertions on every cycle. A short or out-of-range request leaves the block idle with nothing on the mailbox. A stalled dword holds its value. No dword is presented while a finished response waits. A clear empties the count and the flag.

The header field values, the next-handle terminator, the payload addresses of each entry and the exact one-dword-per-clock timing can only be shown by the bench. Its reference model predicts every dword for several handles, request lengths and stall patterns.

// File: rtl/tam_pkg.sv
package tam_pkg;
  localparam int HDR_DW   = 3;   // response header dwords
  localparam int REQ_DW   = 3;   // minimum request object length
  localparam int HANDLE_W = 16;

  function automatic int ent_bytes(input int idx, input int b0, input int step);
    return b0 + step * idx;
  endfunction

  function automatic int ent_dw(input int idx, input int b0, input int step);
    return (ent_bytes(idx, b0, step) + 3) / 4;
  endfunction

  function automatic int ent_base(input int idx, input int b0, input int step);
    int acc;
    acc = 0;
    for (int i = 0; i < idx; i++) acc += ent_dw(i, b0, step);
    return acc;
  endfunction

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_LAST, ST_HELD} tam_state_e;
endpackage

// File: rtl/tam_table_rom.sv
module tam_table_rom #(
  parameter int          NUM_ENT  = 4,
  parameter int          B0       = 6,
  parameter int          STEP     = 5,
  parameter int          IDX_W    = 2,
  parameter int          BYTES_W  = 16,
  parameter int          AW       = 4,
  parameter logic [15:0] DATA_TAG = 16'hDA7A
) (
  input  logic [IDX_W-1:0]   ent_idx,
  input  logic [AW-1:0]      word_off,
  output logic [BYTES_W-1:0] ent_bytes_o,
  output logic [31:0]        rd_data
);
  localparam int ROM_WORDS = tam_pkg::ent_base(NUM_ENT, B0, STEP);

  logic [AW-1:0]      base_tab  [NUM_ENT];
  logic [BYTES_W-1:0] bytes_tab [NUM_ENT];
  logic [31:0]        store     [ROM_WORDS];
  logic [AW-1:0]      addr;

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_desc
    assign base_tab[e]  = AW'(tam_pkg::ent_base(e, B0, STEP));
    assign bytes_tab[e] = BYTES_W'(tam_pkg::ent_bytes(e, B0, STEP));
  end

  for (genvar a = 0; a < ROM_WORDS; a++) begin : g_store
    assign store[a] = {DATA_TAG, 16'(a)};
  end

  assign ent_bytes_o = bytes_tab[ent_idx];
  assign addr        = base_tab[ent_idx] + word_off;
  assign rd_data     = (addr < AW'(ROM_WORDS)) ? store[addr] : '0;
endmodule

// File: rtl/tam_hdr_gen.sv
module tam_hdr_gen #(
  parameter int          NUM_ENT    = 4,
  parameter int          IDX_W      = 2,
  parameter int          BYTES_W    = 16,
  parameter int          LEN_W      = 18,
  parameter logic [15:0] VENDOR_ID  = 16'h1E98,
  parameter logic [7:0]  OBJ_TYPE   = 8'h02,
  parameter logic [7:0]  RSP_CODE   = 8'h00,
  parameter logic [7:0]  TABLE_TYPE = 8'h00
) (
  input  logic [IDX_W-1:0]                 ent_idx,
  input  logic [BYTES_W-1:0]               ent_bytes,
  output logic [tam_pkg::HDR_DW-1:0][31:0] hdr_w,
  output logic [LEN_W-1:0]                 total_dw
);
  logic [BYTES_W:0]                  pay_dw;
  logic [tam_pkg::HANDLE_W-1:0]      next_h;

  always_comb begin
    pay_dw   = ({1'b0, ent_bytes} + (BYTES_W+1)'(3)) >> 2;
    total_dw = LEN_W'(tam_pkg::HDR_DW) + LEN_W'(pay_dw);
    next_h   = (ent_idx == IDX_W'(NUM_ENT - 1)) ? '1
                                                : tam_pkg::HANDLE_W'(ent_idx) + 1'b1;
    hdr_w[0] = {8'h00, OBJ_TYPE, VENDOR_ID};
    hdr_w[1] = 32'(total_dw);
    hdr_w[2] = {next_h, TABLE_TYPE, RSP_CODE};
  end
endmodule

// File: rtl/tam_stream_ctrl.sv
module tam_stream_ctrl #(
  parameter int LEN_W = 18
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [tam_pkg::HDR_DW-1:0][31:0] hdr_w,
  input  logic [LEN_W-1:0]                 total_dw,
  input  logic [31:0]                      pay_word,
  output logic [LEN_W-1:0]                 word_idx,
  output logic                             idle,
  output logic                             out_valid,
  output logic [31:0]                      out_data,
  input  logic                             out_ready,
  output logic                             done,
  output logic [LEN_W-1:0]                 mbox_len,
  input  logic                             mbox_clear
);
  import tam_pkg::*;

  tam_state_e  st;
  logic [31:0] cur_word;

  assign idle     = (st == ST_IDLE);
  assign cur_word = (word_idx < LEN_W'(HDR_DW)) ? hdr_w[word_idx[1:0]] : pay_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      word_idx  <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      done      <= 1'b0;
      mbox_len  <= '0;
    end else begin
      if (mbox_clear) begin
        done     <= 1'b0;
        mbox_len <= '0;
        if (st == ST_HELD) st <= ST_IDLE;
      end
      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_SEND;
          word_idx <= '0;
        end
        ST_SEND: if (!out_valid || out_ready) begin
          out_valid <= 1'b1;
          out_data  <= cur_word;
          word_idx  <= word_idx + 1'b1;
          if (word_idx == total_dw - 1'b1) st <= ST_LAST;
        end
        ST_LAST: if (out_ready) begin
          out_valid <= 1'b0;
          done      <= 1'b1;
          mbox_len  <= mbox_len + total_dw;
          st        <= ST_HELD;
        end
        default: ;
      endcase
    end
  end

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid && !idle);
  a_r8_len_on_done: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> mbox_len >= total_dw);
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    mbox_clear && st == ST_HELD |=> !done && mbox_len == '0 && idle);
endmodule

// File: rtl/tam_responder.sv
module tam_responder #(
  parameter int          NUM_ENT    = 4,
  parameter int          ENT_B0     = 6,
  parameter int          ENT_STEP   = 5,
  parameter int          LEN_W      = 18,
  parameter int          BYTES_W    = 16,
  parameter logic [15:0] VENDOR_ID  = 16'h1E98,
  parameter logic [7:0]  OBJ_TYPE   = 8'h02,
  parameter logic [7:0]  RSP_CODE   = 8'h00,
  parameter logic [7:0]  TABLE_TYPE = 8'h00,
  parameter logic [15:0] DATA_TAG   = 16'hDA7A
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          req_valid,
  input  logic [LEN_W-1:0]              req_len_dw,
  input  logic [tam_pkg::HANDLE_W-1:0]  req_handle,
  output logic                          req_ready,
  output logic                          rd_valid,
  output logic [31:0]                   rd_data,
  input  logic                          rd_ready,
  output logic                          rsp_ready,
  output logic [LEN_W-1:0]              mbox_len_dw,
  input  logic                          mbox_clear
);
  localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
  localparam int ROM_WORDS = tam_pkg::ent_base(NUM_ENT, ENT_B0, ENT_STEP);
  localparam int AW        = $clog2(ROM_WORDS + 1);

  logic [IDX_W-1:0]                 ent_q;
  logic                             req_ok, idle;
  logic [BYTES_W-1:0]               ent_bytes;
  logic [tam_pkg::HDR_DW-1:0][31:0] hdr_w;
  logic [LEN_W-1:0]                 total_dw, word_idx;
  logic [AW-1:0]                    word_off;
  logic [31:0]                      pay_word;

  assign req_ready = idle;
  assign req_ok    = req_valid && idle
                   && (req_len_dw >= LEN_W'(tam_pkg::REQ_DW))
                   && (req_handle < tam_pkg::HANDLE_W'(NUM_ENT));
  assign word_off  = (word_idx >= LEN_W'(tam_pkg::HDR_DW))
                   ? AW'(word_idx - LEN_W'(tam_pkg::HDR_DW)) : '0;

  always_ff @(posedge clk) begin
    if (rst)         ent_q <= '0;
    else if (req_ok) ent_q <= req_handle[IDX_W-1:0];
  end

  tam_table_rom #(
    .NUM_ENT(NUM_ENT), .B0(ENT_B0), .STEP(ENT_STEP), .IDX_W(IDX_W),
    .BYTES_W(BYTES_W), .AW(AW), .DATA_TAG(DATA_TAG)
  ) u_rom (
    .ent_idx(ent_q), .word_off(word_off), .ent_bytes_o(ent_bytes), .rd_data(pay_word)
  );

  tam_hdr_gen #(
    .NUM_ENT(NUM_ENT), .IDX_W(IDX_W), .BYTES_W(BYTES_W), .LEN_W(LEN_W),
    .VENDOR_ID(VENDOR_ID), .OBJ_TYPE(OBJ_TYPE), .RSP_CODE(RSP_CODE),
    .TABLE_TYPE(TABLE_TYPE)
  ) u_hdr (
    .ent_idx(ent_q), .ent_bytes(ent_bytes), .hdr_w(hdr_w), .total_dw(total_dw)
  );

  tam_stream_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(req_ok), .hdr_w(hdr_w), .total_dw(total_dw),
    .pay_word(pay_word), .word_idx(word_idx), .idle(idle),
    .out_valid(rd_valid), .out_data(rd_data), .out_ready(rd_ready),
    .done(rsp_ready), .mbox_len(mbox_len_dw), .mbox_clear(mbox_clear)
  );

  a_r1_short_drop: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_len_dw < LEN_W'(tam_pkg::REQ_DW)
    |=> req_ready && !rd_valid);
  a_r2_bad_handle_drop: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_handle >= tam_pkg::HANDLE_W'(NUM_ENT)
    |=> req_ready && !rd_valid);
endmodule

// File: tb/tb_tam_responder.sv
module tb_tam_responder;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [17:0] req_len_dw = '0;
  logic [15:0] req_handle = '0;
  logic        req_ready, rd_valid, rsp_ready;
  logic [31:0] rd_data;
  logic        rd_ready = 1'b0;
  logic [17:0] mbox_len_dw;
  logic        mbox_clear = 1'b0;

  int n_chk = 0, n_err = 0;
  int rdy_mode = 0, cyc_cnt = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        prev_stall = 1'b0;
  logic [31:0] prev_data = '0;

  always #5 clk = ~clk;

  tam_responder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_len_dw(req_len_dw),
    .req_handle(req_handle), .req_ready(req_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready), .rsp_ready(rsp_ready),
    .mbox_len_dw(mbox_len_dw), .mbox_clear(mbox_clear)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ready pattern driven just after each rising edge
  always @(posedge clk) begin
    #1;
    cyc_cnt++;
    case (rdy_mode)
      0: rd_ready = 1'b1;
      1: rd_ready = (cyc_cnt % 3) != 0;
      default: rd_ready = (cyc_cnt % 4) < 2;
    endcase
  end

  // reference comparison every clock, mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall) begin
        chk(rd_valid == 1'b1, "R7 stall valid", 32'(rd_valid), 32'd1);
        chk(rd_data == prev_data, "R7 stall data", rd_data, prev_data);
      end
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected word", rd_data, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rd_data == e, t, rd_data, e);
        end
      end
      prev_stall = rd_valid && !rd_ready;
      prev_data  = rd_data;
    end
  end

  function automatic int nbytes(input int h); return 6 + 5 * h; endfunction
  function automatic int ndw(input int h); return (nbytes(h) + 3) / 4; endfunction
  function automatic int basew(input int h);
    int s = 0;
    for (int i = 0; i < h; i++) s += ndw(i);
    return s;
  endfunction

  task automatic run_req(input int h, input int len, input int mode);
    int tot, cyc, first, fin;
    tot = 3 + ndw(h);
    exp_q.push_back({8'h00, 8'h02, 16'h1E98}); tag_q.push_back("R3 hdr0");
    exp_q.push_back(32'(tot));                 tag_q.push_back("R4 hdr1");
    exp_q.push_back({(h == NE - 1) ? 16'hFFFF : 16'(h + 1), 8'h00, 8'h00});
    tag_q.push_back("R5 hdr2");
    for (int k = 0; k < ndw(h); k++) begin
      exp_q.push_back({16'hDA7A, 16'(basew(h) + k)}); tag_q.push_back("R6 payload");
    end
    rdy_mode = mode;
    @(posedge clk); #2;
    req_valid = 1'b1; req_len_dw = 18'(len); req_handle = 16'(h);
    @(posedge clk); #2;
    req_valid = 1'b0;
    cyc = 0; first = -1; fin = -1;
    while (fin < 0 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      if (first < 0 && rd_valid) first = cyc;
      if (rsp_ready) fin = cyc;
      else if (req_ready) chk(1'b0, "R8 req_ready while busy", 32'd1, 32'd0);
    end
    chk(fin > 0, "R8 rsp_ready raised", 32'(fin), 32'd1);
    if (mode == 0) begin
      chk(first == 2, "R7 first word latency", 32'(first), 32'd2);
      chk(fin - first == tot, "R7 one word per clock", 32'(fin - first), 32'(tot));
    end
    chk(exp_q.size() == 0, "R6 all words delivered", 32'(exp_q.size()), 32'd0);
    chk(mbox_len_dw == 18'(tot), "R8 mailbox length", 32'(mbox_len_dw), 32'(tot));
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b0 && rsp_ready == 1'b1, "R8 held until clear",
        {req_ready, rsp_ready}, 32'b01);
    chk(rd_valid == 1'b0, "R8 no word while held", 32'(rd_valid), 32'd0);
    @(posedge clk); #2 mbox_clear = 1'b1;
    @(posedge clk); #2 mbox_clear = 1'b0;
    @(negedge clk);
    chk(rsp_ready == 1'b0 && mbox_len_dw == '0 && req_ready == 1'b1, "R9 clear",
        {rsp_ready, req_ready, 12'h0, mbox_len_dw}, 32'h4000_0000);
    exp_q.delete(); tag_q.delete();
  endtask

  task automatic drop_req(input int h, input int len, input string req);
    rdy_mode = 0;
    @(posedge clk); #2;
    req_valid = 1'b1; req_len_dw = 18'(len); req_handle = 16'(h);
    @(posedge clk); #2;
    req_valid = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(rd_valid == 1'b0 && req_ready == 1'b1, req, {rd_valid, req_ready}, 32'b01);
    end
    chk(mbox_len_dw == '0 && rsp_ready == 1'b0, req,
        {rsp_ready, 13'h0, mbox_len_dw}, 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R10 reset rd_valid", 32'(rd_valid), 32'd0);
    chk(rsp_ready == 1'b0, "R10 reset rsp_ready", 32'(rsp_ready), 32'd0);
    chk(mbox_len_dw == '0, "R10 reset mbox_len", 32'(mbox_len_dw), 32'd0);
    chk(req_ready == 1'b1, "R10 reset req_ready", 32'(req_ready), 32'd1);

    run_req(0, 3, 0);                   // minimal valid request, full throughput
    run_req(3, 3, 1);                   // last entry: terminator handle, stalls
    run_req(1, 7, 2);                   // longer request accepted, burst stalls
    drop_req(0, 2, "R1 short request dropped");
    drop_req(2, 0, "R1 zero-length request dropped");
    drop_req(4, 3, "R2 handle past end dropped");
    drop_req(16'hFFFF, 5, "R2 all-ones handle dropped");
    run_req(2, 3, 0);                   // block still works after drops
    run_req(3, 4, 0);                   // walk ends with terminator at full speed

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule